// File: doc/BRIEF.md
# FIFO DMA Request and Interrupt Logic

This block produces the interrupt and DMA request outputs of a data converter that buffers its results in a FIFO. Eight single-cycle condition pulses from elsewhere in the converter are caught in a sticky status register. The status register is gated by an enable mask, and any surviving bit pulls the active-low interrupt line down. When software reads the status register, every pending bit is cleared. A condition that arrives in the same cycle as that read is kept for the next read.

The same enable register also holds a FIFO occupancy count. The DMA request rises when the FIFO count equals that programmed count exactly, and only while the FIFO is not empty. Once raised, it stays high while the count moves in either direction. It drops only when the FIFO empty flag is seen. The FIFO and the logic that produces each condition sit outside the block.

Top module: `irq_dma_ctl`

## Requirements
- R1: After reset, `irq_n_o` is 1, `dma_req_o` is 0, `stat_o` is all zeros, and the enable mask and programmed count are both zero.
- R2: A 1 on bit i of `cond_i` at a clock edge sets bit i of `stat_o` from that edge on. The bit stays set on later edges until a status read clears it.
- R3: A status read (`stat_rd_i` high at an edge) clears all status bits at that edge, except those bits whose `cond_i` bit is high at the same edge. Those bits read as 1 afterwards.
- R4: `irq_n_o` is 0 exactly when the bitwise AND of `stat_o` and the current enable mask is nonzero. A masked condition is still recorded in `stat_o` but does not lower `irq_n_o`.
- R5: `en_wr_i` high at an edge loads `en_mask_i` into the mask and `en_thr_i` into the programmed count. Both new values take effect from that edge on.
- R6: When `fifo_empty_i` is 0 and `fifo_cnt_i` equals the programmed count at an edge, `dma_req_o` is 1 after that edge.
- R7: Once `dma_req_o` is 1, it stays 1 at every edge where `fifo_empty_i` is 0, whatever `fifo_cnt_i` is.
- R8: `fifo_empty_i` high at an edge makes `dma_req_o` 0 after that edge. This holds even if `fifo_cnt_i` equals the programmed count at that edge.
- R9: A FIFO count that goes from below the programmed count to above it without ever being equal to it does not raise `dma_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | N_SRC | One-cycle interrupt condition pulses, one bit per source |
| stat_rd_i | input | 1 | Status register read strobe; clears pending bits |
| stat_o | output | N_SRC | Current status register contents |
| en_wr_i | input | 1 | Enable register write strobe |
| en_mask_i | input | N_SRC | Interrupt enable mask to load (1 = enabled) |
| en_thr_i | input | CNT_W | FIFO count that triggers the DMA request |
| fifo_cnt_i | input | CNT_W | Current FIFO occupancy |
| fifo_empty_i | input | 1 | FIFO empty flag |
| irq_n_o | output | 1 | Active-low interrupt |
| dma_req_o | output | 1 | Active-high DMA request |

## Verification
The hardest case to reach from the ports is a condition pulse that lands in exactly the same cycle as a status read. The stimulus places one on purpose, with both strobes driven in the same cycle, and the random phase keeps producing such overlaps. The DMA side is harder in two ways. One is a count that jumps past the programmed value without matching it. The other is a count that equals the programmed value while the empty flag is high. The stimulus drives both directly, because the count and empty inputs are free-running ports and no real FIFO sits behind them. A behavioural model in the bench is compared with the outputs on every cycle.

// File: rtl/irq_dma_ctl.sv
module irq_dma_ctl #(
  parameter int N_SRC = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] cond_i,
  input  logic             stat_rd_i,
  output logic [N_SRC-1:0] stat_o,
  input  logic             en_wr_i,
  input  logic [N_SRC-1:0] en_mask_i,
  input  logic [CNT_W-1:0] en_thr_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             fifo_empty_i,
  output logic             irq_n_o,
  output logic             dma_req_o
);

  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] mask_q;
  logic [CNT_W-1:0] thr_q;
  logic             dma_q;

  logic [N_SRC-1:0] stat_keep;
  logic             cnt_hit;

  assign stat_keep = stat_rd_i ? '0 : stat_q;
  assign cnt_hit   = (fifo_cnt_i == thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_keep | cond_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      thr_q  <= '0;
    end else if (en_wr_i) begin
      mask_q <= en_mask_i;
      thr_q  <= en_thr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dma_q <= 1'b0;
    else if (fifo_empty_i) dma_q <= 1'b0;
    else if (cnt_hit)      dma_q <= 1'b1;
  end

  assign stat_o    = stat_q;
  assign irq_n_o   = ~|(stat_q & mask_q);
  assign dma_req_o = dma_q;

endmodule

module irq_dma_chk #(
  parameter int N_SRC = 8,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] cond_i,
  input logic             stat_rd_i,
  input logic [N_SRC-1:0] stat_o,
  input logic             en_wr_i,
  input logic [CNT_W-1:0] thr_q,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic             fifo_empty_i,
  input logic             irq_n_o,
  input logic             dma_req_o
);

  a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)) &&
                   ((stat_o & $past(cond_i)) == $past(cond_i)));

  a_r3_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |=> (stat_o == $past(cond_i)));

  a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !stat_rd_i && !en_wr_i) |=> !irq_n_o);

  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o == '0) |-> irq_n_o);

  a_r6_match_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty_i && fifo_cnt_i == thr_q) |=> dma_req_o);

  a_r7_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && !fifo_empty_i) |=> dma_req_o);

  a_r8_empty_drop: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty_i |=> !dma_req_o);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req_o && fifo_cnt_i != thr_q) |=> !dma_req_o);

endmodule

bind irq_dma_ctl irq_dma_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .stat_rd_i(stat_rd_i),
  .stat_o(stat_o), .en_wr_i(en_wr_i), .thr_q(thr_q),
  .fifo_cnt_i(fifo_cnt_i), .fifo_empty_i(fifo_empty_i),
  .irq_n_o(irq_n_o), .dma_req_o(dma_req_o)
);

// File: tb/tb_irq_dma_ctl.sv
module tb_irq_dma_ctl;
  localparam int N = 8;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cond = '0;
  logic rd = 1'b0;
  logic [N-1:0] stat;
  logic ewr = 1'b0;
  logic [N-1:0] emask = '0;
  logic [W-1:0] ethr = '0;
  logic [W-1:0] cnt = '0;
  logic empty = 1'b1;
  logic irq_n, dma;

  always #5 clk = ~clk;

  irq_dma_ctl #(.N_SRC(N), .CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .stat_rd_i(rd), .stat_o(stat),
    .en_wr_i(ewr), .en_mask_i(emask), .en_thr_i(ethr),
    .fifo_cnt_i(cnt), .fifo_empty_i(empty), .irq_n_o(irq_n), .dma_req_o(dma)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_pend [N];
  bit m_en [N];
  int m_thr;
  bit m_dma;

  task automatic check(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_pend[i] <= 0; m_en[i] <= 0; end
      m_thr <= 0;
      m_dma <= 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cond[i]) m_pend[i] <= 1;
        else if (rd) m_pend[i] <= 0;
        if (ewr) m_en[i] <= emask[i];
      end
      if (ewr) m_thr <= int'(ethr);
      if (empty) m_dma <= 0;
      else if (int'(cnt) == m_thr) m_dma <= 1;
    end
  end

  function automatic int exp_stat();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_pend[i]) v += (1 << i);
    return v;
  endfunction

  function automatic int exp_irq_n();
    for (int i = 0; i < N; i++) if (m_pend[i] && m_en[i]) return 0;
    return 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(tag, int'(stat), exp_stat(), "stat_o");
      check(tag, int'(irq_n), exp_irq_n(), "irq_n_o");
      check(tag, int'(dma), int'(m_dma), "dma_req_o");
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_strobes();
    cond = '0; rd = 0; ewr = 0;
  endtask

  task automatic write_en(logic [N-1:0] m, logic [W-1:0] t);
    ewr = 1; emask = m; ethr = t;
    step(); clear_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step();
    tag = "R1";
    check("R1", int'(irq_n), 1, "irq_n_o after reset");
    check("R1", int'(dma), 0, "dma_req_o after reset");
    check("R1", int'(stat), 0, "stat_o after reset");

    tag = "R5";
    write_en(8'h0F, 5'd4);
    step();

    tag = "R4";
    cond = 8'h20; step(); clear_strobes();
    check("R4", int'(stat), 'h20, "masked source recorded");
    check("R4", int'(irq_n), 1, "masked source keeps irq high");

    tag = "R2";
    cond = 8'h02; step(); clear_strobes();
    step(3);
    check("R2", int'(stat), 'h22, "sticky bits held");
    check("R2", int'(irq_n), 0, "enabled source lowers irq");

    tag = "R3";
    rd = 1; step(); clear_strobes();
    check("R3", int'(stat), 0, "read clears status");
    check("R3", int'(irq_n), 1, "read releases irq");
    rd = 1; cond = 8'h04; step(); clear_strobes();
    check("R3", int'(stat), 'h04, "condition in read cycle kept");
    check("R3", int'(irq_n), 0, "kept condition lowers irq");

    tag = "R5";
    write_en(8'h00, 5'd4);
    check("R5", int'(irq_n), 1, "mask cleared releases irq");
    write_en(8'h04, 5'd4);
    check("R5", int'(irq_n), 0, "mask restored lowers irq");
    rd = 1; step(); clear_strobes();

    tag = "R6";
    empty = 0;
    for (int c = 1; c <= 3; c++) begin cnt = W'(c); step(); end
    check("R6", int'(dma), 0, "below count");
    cnt = 5'd4; step();
    check("R6", int'(dma), 1, "equal count raises dma");

    tag = "R7";
    cnt = 5'd6; step();
    cnt = 5'd2; step();
    check("R7", int'(dma), 1, "held while count moves");
    cnt = 5'd0; empty = 1; step();
    check("R7", int'(dma), 0, "drops on empty");

    tag = "R9";
    write_en(8'h04, 5'd6);
    empty = 0; cnt = 5'd5; step();
    cnt = 5'd7; step();
    cnt = 5'd9; step();
    check("R9", int'(dma), 0, "skipped count does not raise");

    tag = "R8";
    empty = 1; cnt = 5'd0; step();
    write_en(8'h04, 5'd3);
    cnt = 5'd3; empty = 1; step();
    check("R8", int'(dma), 0, "empty wins over match");
    write_en(8'h04, 5'd0);
    cnt = 5'd0; empty = 1; step(2);
    check("R8", int'(dma), 0, "zero count while empty");

    tag = "R2 R3 R4 R6 R7 R8 random";
    for (int k = 0; k < 600; k++) begin
      cond = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      rd = ($urandom_range(0, 4) == 0);
      ewr = ($urandom_range(0, 15) == 0);
      emask = N'($urandom);
      ethr = W'($urandom_range(0, 7));
      cnt = W'($urandom_range(0, 7));
      empty = ($urandom_range(0, 5) == 0);
      step();
    end
    clear_strobes();
    step(2);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule